// File: doc/BRIEF.md
# Posted Write Buffer Slave

This block is the write half of a bridge slave that sits on a simple select/acknowledge/retry peripheral bus. It takes a write from an upstream master, acknowledges every word at once and stores it in a small word buffer. It then raises a single request toward the downstream master side of the bridge. That request is either a single-word write that carries the master's byte-enable pattern, or a burst of an exact, known word count with all byte lanes enabled.

While the request is outstanding, the block answers every new select with a one-cycle retry, which forces the master off the bus. The downstream side reads the buffered words in order through a pop interface and ends the transaction with a completion pulse. Any error flag that comes with that pulse is thrown away on purpose: once a write is posted, there is no way to tell the master that it failed. After completion the block is idle and accepts the next write, whatever its address.

The sequential-address qualifier on the first beat selects single or burst. Bursts must start word-aligned. A burst stops at the end of the address window it started in, even when the next window follows directly, and it also stops once the buffer holds its full depth of words.

Top module: `pwb_slave`

## Requirements
- R1: After reset, up_ack, up_retry and dn_req are 0, dn_len is 0, and the first write presented is acknowledged.
- R2: A write beat whose qualifier up_seq is 0 on the first beat is acknowledged. On the next cycle dn_req is 1 with dn_single=1, dn_len=1, dn_be equal to the captured up_be, and dn_addr equal to up_addr with bits [1:0] forced to 00.
- R3: A write whose first beat has up_seq=1 and up_addr[1:0]=00 is a burst. Each beat is acknowledged one cycle after it is presented (after the cycle in which the previous acknowledge is seen). When up_sel falls, a request follows with dn_single=0, dn_len equal to the number of words, dn_be=4'b1111 and dn_addr equal to the start address.
- R4: A burst holds at most DEPTH (16) words. The 16th beat is acknowledged and hands the request off with dn_len=16, and a 17th beat receives a retry, not an acknowledge.
- R5: A burst beat whose address is above the high end of the window that contained the burst's first beat receives a retry, not an acknowledge, even if another window begins at that address. The request length then counts only the words inside the window.
- R6: While a request is outstanding, every new select, whether read or write and in or out of any window, is answered with up_retry high for exactly one cycle, and never with an acknowledge.
- R7: up_ack and up_retry are never high in the same cycle.
- R8: A dn_done pulse ends the request: dn_req is 0 on the next cycle and the next write is accepted. The value of dn_err has no effect on anything at the upstream port.
- R9: In idle, a select whose address lies in no window, or whose up_rnw is 1 (read), gets neither acknowledge nor retry and raises no request.
- R10: A burst first beat (up_seq=1) with up_addr[1:0] not 00 is not claimed: no acknowledge, no retry, no request.
- R11: Each write is a new transaction. Two writes to the same address produce two separate requests, each carrying its own data.
- R12: During a request, dn_data shows the oldest unread buffered word, and each cycle with dn_pop high advances to the next word in the order written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_sel | input | 1 | Upstream select, held until acknowledge or retry |
| up_rnw | input | 1 | Direction, 1 = read, 0 = write |
| up_be | input | 4 | Byte-enable pattern for a single write |
| up_seq | input | 1 | Sequential-address qualifier, sampled on the first beat |
| up_addr | input | 32 | Beat byte address |
| up_wdata | input | 32 | Beat write data |
| up_ack | output | 1 | Transfer acknowledge |
| up_retry | output | 1 | Retry, master must release the bus |
| dn_req | output | 1 | Downstream request pending |
| dn_single | output | 1 | 1 = single write with byte enables, 0 = fixed burst |
| dn_addr | output | 32 | Word-aligned start address |
| dn_be | output | 4 | Byte enables of the request |
| dn_len | output | 5 | Word count of the request, 1 to DEPTH |
| dn_data | output | 32 | Oldest unread buffered word |
| dn_pop | input | 1 | Advance to the next buffered word |
| dn_done | input | 1 | Completion pulse of the downstream request |
| dn_err | input | 1 | Error flag with completion, discarded |

## Verification
Single writes are swept over all sixteen byte-enable patterns with varied low address bits. This separates correct capture of the byte-enable pattern from correct alignment of the address. Bursts are swept over every length from 1 to 16, which tests the word counting at each boundary, including the full-depth case, against overflow past the 17th beat. Bursts that start near the end of the first window check that the range limit is taken from the starting window and not from the address decode in general. A string of mixed selects during a pending request, followed by completions with and without the error flag, checks that blocking lasts exactly as long as the request and that an error leaves nothing behind.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_HOLD = 2'd2
    } pwb_state_e;

endpackage

// File: rtl/pwb_rng_dec.sv
module pwb_rng_dec #(
    parameter int                      NUM_RNG  = 2,
    parameter logic [NUM_RNG*32-1:0]   RNG_BASE = {32'h1000_0040, 32'h1000_0000},
    parameter logic [NUM_RNG*32-1:0]   RNG_HIGH = {32'h1000_00FF, 32'h1000_003F}
) (
    input  logic [31:0] addr,
    output logic        hit,
    output logic [31:0] hit_high
);

    logic [NUM_RNG-1:0] hit_v;
    logic [31:0]        high_v [NUM_RNG];

    for (genvar g = 0; g < NUM_RNG; g++) begin : g_win
        localparam logic [31:0] LO = RNG_BASE[g*32 +: 32];
        localparam logic [31:0] HI = RNG_HIGH[g*32 +: 32];
        assign hit_v[g]  = (addr >= LO) && (addr <= HI);
        assign high_v[g] = HI;
    end

    // lowest-numbered matching window wins
    always_comb begin
        hit_high = '0;
        for (int i = NUM_RNG - 1; i >= 0; i--) begin
            if (hit_v[i]) hit_high = high_v[i];
        end
    end

    assign hit = |hit_v;

endmodule

// File: rtl/pwb_wbuf.sv
module pwb_wbuf #(
    parameter int DEPTH = 16,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_pop,
    output logic [DW-1:0] rd_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [FW-1:0] fill;
    } buf_t;

    buf_t          q, d;
    logic [DW-1:0] mem [DEPTH];
    logic          do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign do_pop = rd_pop && (q.fill != '0);

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (wr_en)  d.wr_ptr = bump(q.wr_ptr);
            if (do_pop) d.rd_ptr = bump(q.rd_ptr);
            d.fill = q.fill + FW'(wr_en) - FW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) mem[q.wr_ptr] <= wr_data;
    end

    assign rd_data = mem[q.rd_ptr];

    // R4: the controller never writes into a full buffer
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (q.fill < FW'(DEPTH)));

    // R12: the downstream side only pops words that exist
    a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |-> (q.fill != '0));

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         up_sel,
    input  logic                         up_rnw,
    input  logic [3:0]                   up_be,
    input  logic                         up_seq,
    input  logic [31:0]                  up_addr,
    input  logic                         rng_hit,
    input  logic [31:0]                  rng_high,
    input  logic                         dn_done,
    input  logic                         dn_err,
    output logic                         up_ack,
    output logic                         up_retry,
    output logic                         wr_en,
    output logic                         clr,
    output logic                         dn_req,
    output logic                         dn_single,
    output logic [31:0]                  dn_addr,
    output logic [3:0]                   dn_be,
    output logic [$clog2(DEPTH+1)-1:0]   dn_len
);

    localparam int LEN_W = $clog2(DEPTH + 1);

    typedef struct packed {
        pwb_state_e       st;
        logic             ack;
        logic             retry;
        logic             single;
        logic [29:0]      waddr;
        logic [3:0]       be;
        logic [31:0]      lim;
        logic [LEN_W-1:0] cnt;
    } ctl_t;

    ctl_t q, d;
    logic fresh;
    logic in_window;
    logic last_word;

    // a select not yet answered
    assign fresh     = up_sel && !q.ack && !q.retry;
    assign in_window = (up_addr <= q.lim);
    assign last_word = (q.cnt + LEN_W'(1)) == LEN_W'(DEPTH);

    always_comb begin
        d       = q;
        d.ack   = 1'b0;
        d.retry = 1'b0;
        wr_en   = 1'b0;
        clr     = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (fresh && !up_rnw && rng_hit) begin
                    if (!up_seq) begin
                        d.ack    = 1'b1;
                        wr_en    = 1'b1;
                        d.single = 1'b1;
                        d.waddr  = up_addr[31:2];
                        d.be     = up_be;
                        d.cnt    = LEN_W'(1);
                        d.st     = ST_HOLD;
                    end else if (up_addr[1:0] == 2'b00) begin
                        d.ack    = 1'b1;
                        wr_en    = 1'b1;
                        d.single = 1'b0;
                        d.waddr  = up_addr[31:2];
                        d.be     = 4'hF;
                        d.lim    = rng_high;
                        d.cnt    = LEN_W'(1);
                        d.st     = (DEPTH == 1) ? ST_HOLD : ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (!up_sel) begin
                    d.st = ST_HOLD;
                end else if (fresh) begin
                    if (in_window) begin
                        d.ack = 1'b1;
                        wr_en = 1'b1;
                        d.cnt = q.cnt + LEN_W'(1);
                        if (last_word) d.st = ST_HOLD;
                    end else begin
                        d.retry = 1'b1;
                        d.st    = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (fresh) d.retry = 1'b1;
                if (dn_done) begin
                    clr   = 1'b1;
                    d.cnt = '0;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign up_ack    = q.ack;
    assign up_retry  = q.retry;
    assign dn_req    = (q.st == ST_HOLD);
    assign dn_single = q.single;
    assign dn_addr   = {q.waddr, 2'b00};
    assign dn_be     = q.be;
    assign dn_len    = q.cnt;

    // R7
    a_r7_ack_retry_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_ack && up_retry));

    // R6: retry is a one-cycle answer
    a_r6_retry_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        up_retry |=> !up_retry);

    // R6: no acknowledge once a request has been pending for a cycle
    a_r6_no_ack_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && $past(dn_req)) |-> !up_ack);

    // R8: request stays up until completion
    a_r8_req_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_done) |=> dn_req);

    // R8: an error with completion does not keep the request alive
    a_r8_err_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_done && dn_err) |=> !dn_req);

    // R4: length of any request lies in 1..DEPTH
    a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> ((dn_len != '0) && (dn_len <= LEN_W'(DEPTH))));

    // R2: a single write is always one word
    a_r2_single_len: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_single) |-> (dn_len == LEN_W'(1)));

endmodule

// File: rtl/pwb_slave.sv
module pwb_slave
    import pwb_pkg::*;
#(
    parameter int                    DEPTH    = 16,
    parameter int                    NUM_RNG  = 2,
    parameter logic [NUM_RNG*32-1:0] RNG_BASE = {32'h1000_0040, 32'h1000_0000},
    parameter logic [NUM_RNG*32-1:0] RNG_HIGH = {32'h1000_00FF, 32'h1000_003F}
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       up_sel,
    input  logic                       up_rnw,
    input  logic [3:0]                 up_be,
    input  logic                       up_seq,
    input  logic [31:0]                up_addr,
    input  logic [31:0]                up_wdata,
    output logic                       up_ack,
    output logic                       up_retry,
    output logic                       dn_req,
    output logic                       dn_single,
    output logic [31:0]                dn_addr,
    output logic [3:0]                 dn_be,
    output logic [$clog2(DEPTH+1)-1:0] dn_len,
    output logic [31:0]                dn_data,
    input  logic                       dn_pop,
    input  logic                       dn_done,
    input  logic                       dn_err
);

    logic        rng_hit;
    word_t       rng_high;
    logic        wr_en;
    logic        clr;

    pwb_rng_dec #(
        .NUM_RNG  (NUM_RNG),
        .RNG_BASE (RNG_BASE),
        .RNG_HIGH (RNG_HIGH)
    ) u_dec (
        .addr     (up_addr),
        .hit      (rng_hit),
        .hit_high (rng_high)
    );

    pwb_ctrl #(
        .DEPTH (DEPTH)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .up_sel    (up_sel),
        .up_rnw    (up_rnw),
        .up_be     (up_be),
        .up_seq    (up_seq),
        .up_addr   (up_addr),
        .rng_hit   (rng_hit),
        .rng_high  (rng_high),
        .dn_done   (dn_done),
        .dn_err    (dn_err),
        .up_ack    (up_ack),
        .up_retry  (up_retry),
        .wr_en     (wr_en),
        .clr       (clr),
        .dn_req    (dn_req),
        .dn_single (dn_single),
        .dn_addr   (dn_addr),
        .dn_be     (dn_be),
        .dn_len    (dn_len)
    );

    pwb_wbuf #(
        .DEPTH (DEPTH),
        .DW    (32)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .wr_en   (wr_en),
        .wr_data (up_wdata),
        .rd_pop  (dn_pop),
        .rd_data (dn_data)
    );

endmodule

// File: tb/tb_pwb_slave.sv
module tb_pwb_slave;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_sel = 1'b0, up_rnw = 1'b0, up_seq = 1'b0;
    logic [3:0]  up_be = '0;
    logic [31:0] up_addr = '0, up_wdata = '0;
    logic        up_ack, up_retry;
    logic        dn_req, dn_single;
    logic [31:0] dn_addr, dn_data;
    logic [3:0]  dn_be;
    logic [4:0]  dn_len;
    logic        dn_pop = 1'b0, dn_done = 1'b0, dn_err = 1'b0;

    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;
    logic [31:0] exp_w [16];

    always #(CLK_P/2) clk = ~clk;

    pwb_slave dut (
        .clk(clk), .rst_n(rst_n), .up_sel(up_sel), .up_rnw(up_rnw), .up_be(up_be),
        .up_seq(up_seq), .up_addr(up_addr), .up_wdata(up_wdata), .up_ack(up_ack),
        .up_retry(up_retry), .dn_req(dn_req), .dn_single(dn_single), .dn_addr(dn_addr),
        .dn_be(dn_be), .dn_len(dn_len), .dn_data(dn_data), .dn_pop(dn_pop),
        .dn_done(dn_done), .dn_err(dn_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // present one beat; resp: 0 none, 1 ack, 2 retry
    task automatic present(input logic [31:0] a, input logic [31:0] dat, input logic [3:0] be,
                           input logic seq, input logic rnw, output int resp);
        up_sel = 1'b1; up_addr = a; up_wdata = dat; up_be = be; up_seq = seq; up_rnw = rnw;
        resp = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (up_ack || up_retry) begin
                chk(!(up_ack && up_retry), "R7 ack/retry overlap", {30'd0, up_ack, up_retry}, 32'd2);
                resp = up_ack ? 1 : 2;
                return;
            end
        end
    endtask

    task automatic release_bus();
        up_sel = 1'b0; up_seq = 1'b0; up_rnw = 1'b0;
        @(negedge clk);
    endtask

    task automatic drain_done(input int n, input logic err, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(dn_data == exp_w[i], {tag, " R12 word"}, dn_data, exp_w[i]);
            dn_pop = 1'b1;
            @(negedge clk);
        end
        dn_pop = 1'b0;
        dn_done = 1'b1; dn_err = err;
        @(negedge clk);
        dn_done = 1'b0; dn_err = 1'b0;
        chk(dn_req == 1'b0, {tag, " R8 req cleared"}, {31'd0, dn_req}, 32'd0);
    endtask

    task automatic check_req(input logic single, input logic [31:0] a, input logic [3:0] be,
                             input int len, input string tag);
        chk(dn_req == 1'b1, {tag, " req"}, {31'd0, dn_req}, 32'd1);
        chk(dn_single == single, {tag, " single"}, {31'd0, dn_single}, {31'd0, single});
        chk(dn_addr == {a[31:2], 2'b00}, {tag, " addr"}, dn_addr, {a[31:2], 2'b00});
        chk(dn_be == be, {tag, " be"}, {28'd0, dn_be}, {28'd0, be});
        chk(dn_len == 5'(len), {tag, " len"}, {27'd0, dn_len}, 32'(len));
    endtask

    // offer n burst beats from a; returns acked count and whether a retry stopped it
    task automatic burst(input logic [31:0] a, input int n, input int tagv,
                         output int acked, output bit retried);
        int r;
        acked = 0; retried = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = {8'(tagv), 8'(i), 16'hC35A ^ 16'(i * 7)};
            present(a + 32'(4 * i), w, 4'hF, 1'b1, 1'b0, r);
            if (r == 1) begin
                exp_w[acked] = w;
                acked++;
            end else begin
                retried = (r == 2);
                break;
            end
        end
        release_bus();
    endtask

    initial begin
        int r, acked;
        bit retried;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(up_ack == 0 && up_retry == 0, "R1 reset handshake", {30'd0, up_ack, up_retry}, 32'd0);
        chk(dn_req == 0 && dn_len == 0, "R1 reset request", {26'd0, dn_len, dn_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 single writes over every byte-enable pattern (R1: first one accepted)
        for (int b = 0; b < 16; b++) begin
            logic [31:0] a, w;
            a = 32'h1000_0000 + 32'(b * 4) + 32'(b % 4);
            w = 32'hD000_0000 | 32'(b * 32'h0101);
            exp_w[0] = w;
            present(a, w, 4'(b), 1'b0, 1'b0, r);
            chk(r == 1, (b == 0) ? "R1 first write ack" : "R2 single ack", 32'(r), 32'd1);
            release_bus();
            check_req(1'b1, a, 4'(b), 1, "R2");
            drain_done(1, b[0], "R2/R8");
        end

        // R3 bursts of every length
        for (int n = 1; n <= 16; n++) begin
            burst(32'h1000_0080, n, n, acked, retried);
            chk(acked == n, "R3 burst acked", 32'(acked), 32'(n));
            check_req(1'b0, 32'h1000_0080, 4'hF, n, "R3");
            drain_done(n, 1'b0, "R3");
        end

        // R4 17 beats: 16 taken, 17th retried
        burst(32'h1000_0080, 17, 17, acked, retried);
        chk(acked == 16, "R4 cap acked", 32'(acked), 32'd16);
        chk(retried == 1'b1, "R4 17th retried", {31'd0, retried}, 32'd1);
        check_req(1'b0, 32'h1000_0080, 4'hF, 16, "R4");
        drain_done(16, 1'b0, "R4");

        // R5 window end, next window contiguous
        for (int s = 0; s < 3; s++) begin
            int k;
            k = (s == 0) ? 6 : (s == 1) ? 12 : 15;
            burst(32'h1000_0000 + 32'(4 * k), 16, 40 + k, acked, retried);
            chk(acked == 16 - k, "R5 acked in window", 32'(acked), 32'(16 - k));
            chk(retried == 1'b1, "R5 retry at window end", {31'd0, retried}, 32'd1);
            check_req(1'b0, 32'h1000_0000 + 32'(4 * k), 4'hF, 16 - k, "R5");
            drain_done(16 - k, 1'b0, "R5");
        end

        // R6 blocking while pending
        exp_w[0] = 32'h1234_5678;
        present(32'h1000_0010, 32'h1234_5678, 4'h3, 1'b0, 1'b0, r);
        release_bus();
        for (int j = 0; j < 5; j++) begin
            logic [31:0] a;
            a = (j == 2) ? 32'h2000_0000 : 32'h1000_0020 + 32'(j * 4);
            present(a, 32'hBAD0_0000 | 32'(j), 4'hF, j[0], (j == 3), r);
            chk(r == 2, "R6 retry while pending", 32'(r), 32'd2);
            up_sel = 1'b0;
            @(negedge clk);
            chk(up_retry == 1'b0, "R6 retry one cycle", {31'd0, up_retry}, 32'd0);
        end
        check_req(1'b1, 32'h1000_0010, 4'h3, 1, "R6 request unchanged");
        drain_done(1, 1'b1, "R6/R8");

        // R9 unclaimed selects in idle
        present(32'h2000_0000, 32'h1, 4'hF, 1'b0, 1'b0, r);
        chk(r == 0, "R9 outside windows", 32'(r), 32'd0);
        release_bus();
        present(32'h1000_0000, 32'h1, 4'hF, 1'b0, 1'b1, r);
        chk(r == 0, "R9 read ignored", 32'(r), 32'd0);
        release_bus();
        chk(dn_req == 0, "R9 no request", {31'd0, dn_req}, 32'd0);

        // R10 misaligned burst start
        present(32'h1000_0082, 32'h2, 4'hF, 1'b1, 1'b0, r);
        chk(r == 0, "R10 misaligned burst", 32'(r), 32'd0);
        release_bus();
        chk(dn_req == 0, "R10 no request", {31'd0, dn_req}, 32'd0);

        // R11 same address twice
        for (int t = 0; t < 2; t++) begin
            exp_w[0] = 32'hAB00_0000 + 32'(t);
            present(32'h1000_0044, exp_w[0], 4'hF, 1'b0, 1'b0, r);
            chk(r == 1, "R11 repeat write ack", 32'(r), 32'd1);
            release_bus();
            check_req(1'b1, 32'h1000_0044, 4'hF, 1, "R11");
            drain_done(1, 1'b0, "R11");
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule